// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block is the digital timing core of a segment LCD driver. Software programs one 16-bit mode register. The register turns the display on, enables the common pins, selects the multiplex ratio together with the bias scheme, and sets the slot clock divider. A prescaler runs from a low-frequency input clock. It steps the sequencer through one time slot per common and inverts the drive polarity at every frame boundary, so the panel sees no net DC level. For every common pin and every segment pin, the block outputs a 2-bit level index. An external analog stage turns that index into a bias voltage.

Segment data comes from a small display memory. The block presents the current slot number as a row address, and the memory returns one bit per segment for that row. The returned row is used in the same cycle. Changes to the mode or divider bits are held back until the current frame completes. The new setting then starts cleanly at slot 0.

Top module: `lcd_drive_seq`

## Requirements
- R1: After reset the control register reads 0x0000. Only bits 15, 14, 13, 12, 6:4 and 1:0 are implemented, and every other bit reads 0 (implemented mask 0xF073).
- R2: A write (`wr_en`=1) updates exactly the register bits whose `wr_mask` bit is 1, to the value on `wr_data`. With `wr_mask`=0xFFFF this is a full 16-bit write, and with a single mask bit it is a single-bit write. The register is unchanged while `wr_en`=0.
- R3: Bit 13 drives `ana_stop` and bit 12 drives `int_supply` unchanged. Neither has any effect on slot timing or on the level outputs.
- R4: Each slot lasts 2^(6+d) input clocks, where d is the value of bits 1:0. A frame holds N slots, and `row_addr` equals the current slot number, counting 0 to N-1.
- R5: Mode bits 6:4 select N and the bias: 000 gives N=4 with 1/3 bias, 001 gives N=3 with 1/3, 010 gives N=2 with 1/2, 011 gives N=3 with 1/2, and 100 gives static (N=1). Codes 101 to 111 behave as static and still read back as written.
- R6: The polarity starts at 0 after reset and inverts at every frame boundary. In static mode, common 0 therefore alternates between level 3 and level 0 on successive frames.
- R7: Common level codes for polarity 0/1 are as follows. The selected common (index equal to the slot) is 3/0. With 1/3 bias a non-selected common is 1/2, and with 1/2 bias it is 1 (mid). In static mode common 0 is 0/3.
- R8: Segment level codes for polarity 0/1 are as follows. Select is 0/3 with either bias and 3/0 in static mode. Non-select is 2/1 with 1/3 bias, 3/0 with 1/2 bias and 0/3 in static mode. A segment is selected when bit 15 is 1 and its `seg_row` bit is 1.
- R9: While bit 15 is 0, every segment output carries the non-select code of R8 and the slot timing keeps running.
- R10: While bit 14 is 0, every common output is level 0. Commons with an index at or above N are always level 0.
- R11: A change to mode or divider bits takes effect only at the next frame boundary. The current frame finishes with the old N and the old slot length, and the new setting starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | 16 | Per-bit write enable |
| wr_data | input | 16 | Write data |
| ctrl_rd | output | 16 | Register read-back |
| ana_stop | output | 1 | Stored analog-stop flag (bit 13) |
| int_supply | output | 1 | Stored internal-supply flag (bit 12) |
| row_addr | output | 2 | Display memory row, equals the current slot |
| seg_row | input | NUM_SEG | Segment bits of the addressed row |
| com_lvl | output | 8 | Level index per common, 2 bits each, common i at [2i+1:2i] |
| seg_lvl | output | 2*NUM_SEG | Level index per segment, 2 bits each, segment j at [2j+1:2j] |

## Verification
The hardest case to reach from the ports is a mode or divider write that lands in the middle of a frame. This case separates deferred application from immediate application. The bench waits for a frame start, lets one full slot pass, and then switches from four-way multiplex to static drive. It checks that `row_addr` still reaches slot 3 and then stays at 0. A bench-side reference sequencer, built from the requirement text, is compared with every output on every cycle across several mode, divider, memory-pattern and enable combinations. This includes a reserved mode code and both bias options at three-way multiplex.

// File: rtl/lcd_seq_pkg.sv
// Package: shared constants, types and level tables for the LCD drive
// sequencer. Assumes at most four commons, as set by the mode encoding.
package lcd_seq_pkg;

    localparam int MAX_COM   = 4;
    localparam int SLOT_W    = 2;
    localparam int LVL_W     = 2;

    // Register bit positions; the mode/divider fields are decoded by the timer.
    localparam int BIT_ON    = 15;
    localparam int BIT_COMEN = 14;
    localparam int BIT_ASTOP = 13;
    localparam int BIT_ISUP  = 12;
    localparam int MODE_LSB  = 4;
    localparam int DIV_LSB   = 0;
    localparam logic [15:0] CTRL_IMPL = 16'hF073;

    typedef enum logic [1:0] {
        BIAS_STATIC = 2'd0,
        BIAS_HALF   = 2'd1,
        BIAS_THIRD  = 2'd2
    } bias_e;

    localparam logic [LVL_W-1:0] LV_0   = 2'd0;
    localparam logic [LVL_W-1:0] LV_1   = 2'd1;
    localparam logic [LVL_W-1:0] LV_2   = 2'd2;
    localparam logic [LVL_W-1:0] LV_3   = 2'd3;
    localparam logic [LVL_W-1:0] LV_MID = LV_1;

    // Number of slots per frame for a mode code; reserved codes act static.
    function automatic logic [2:0] slots_of(input logic [2:0] mode);
        case (mode)
            3'b000:  slots_of = 3'd4;
            3'b001:  slots_of = 3'd3;
            3'b010:  slots_of = 3'd2;
            3'b011:  slots_of = 3'd3;
            default: slots_of = 3'd1;
        endcase
    endfunction

    // Bias scheme for a mode code; reserved codes act static.
    function automatic bias_e bias_of(input logic [2:0] mode);
        case (mode)
            3'b000, 3'b001: bias_of = BIAS_THIRD;
            3'b010, 3'b011: bias_of = BIAS_HALF;
            default:        bias_of = BIAS_STATIC;
        endcase
    endfunction

    // Level of an active common for the bias, selection and polarity.
    function automatic logic [LVL_W-1:0] com_level(input bias_e b,
                                                   input logic sel,
                                                   input logic pol);
        case (b)
            BIAS_STATIC: com_level = pol ? LV_3 : LV_0;
            BIAS_HALF:   com_level = sel ? (pol ? LV_0 : LV_3) : LV_MID;
            default:     com_level = sel ? (pol ? LV_0 : LV_3)
                                         : (pol ? LV_2 : LV_1);
        endcase
    endfunction

    // Level of a segment for the bias, selection and polarity.
    function automatic logic [LVL_W-1:0] seg_level(input bias_e b,
                                                   input logic sel,
                                                   input logic pol);
        case (b)
            BIAS_STATIC: seg_level = sel ? (pol ? LV_0 : LV_3)
                                         : (pol ? LV_3 : LV_0);
            BIAS_HALF:   seg_level = sel ? (pol ? LV_3 : LV_0)
                                         : (pol ? LV_0 : LV_3);
            default:     seg_level = sel ? (pol ? LV_3 : LV_0)
                                         : (pol ? LV_1 : LV_2);
        endcase
    endfunction

endpackage

// File: rtl/lcd_ctrl_reg.sv
// Module: 16-bit mode register with per-bit write mask.
// Assumes writes are single-cycle strobes; unimplemented bits stay zero.
module lcd_ctrl_reg
    import lcd_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_mask,
    input  logic [15:0] wr_data,
    output logic [15:0] ctrl_q
);

    logic [15:0] ctrl_next;

    // Merge masked write data into the stored value.
    always_comb begin
        ctrl_next = ((ctrl_q & ~wr_mask) | (wr_data & wr_mask)) & CTRL_IMPL;
    end

    // Hold the register; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_next;
        end
    end

endmodule

// File: rtl/lcd_frame_timer.sv
// Module: prescaler, slot counter and frame polarity. The mode and divider
// are captured at each frame boundary, so a change waits for the frame end.
// Assumes DIV_BASE+3 fits the prescaler width derived below.
module lcd_frame_timer
    import lcd_seq_pkg::*;
#(
    parameter int DIV_BASE = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic [1:0]        cfg_div,
    output logic [SLOT_W-1:0] slot,
    output logic              pol,
    output logic [2:0]        act_mode,
    output logic [1:0]        act_div,
    output logic              frame_end
);

    localparam int PRE_W = DIV_BASE + 4;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_limit;
    logic [2:0]       nslots;
    logic             slot_end;
    logic             last_slot;

    // Slot length and end-of-slot / end-of-frame decode.
    always_comb begin
        pre_limit = ({{(PRE_W-1){1'b0}}, 1'b1} << (DIV_BASE + int'(act_div)))
                    - {{(PRE_W-1){1'b0}}, 1'b1};
        nslots    = slots_of(act_mode);
        slot_end  = (pre_cnt == pre_limit);
        last_slot = ({1'b0, slot} == (nslots - 3'd1));
        frame_end = slot_end && last_slot;
    end

    // Advance prescaler, slot and polarity; latch new config per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            slot     <= '0;
            pol      <= 1'b0;
            act_mode <= 3'b000;
            act_div  <= 2'b00;
        end else if (slot_end) begin
            pre_cnt <= '0;
            if (last_slot) begin
                slot     <= '0;
                pol      <= ~pol;
                act_mode <= cfg_mode;
                act_div  <= cfg_div;
            end else begin
                slot <= slot + {{(SLOT_W-1){1'b0}}, 1'b1};
            end
        end else begin
            pre_cnt <= pre_cnt + {{(PRE_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/lcd_com_drive.sv
// Module: per-common level encoder. Commons beyond the active count, or all
// commons while common enable is low, sit at level 0.
module lcd_com_drive
    import lcd_seq_pkg::*;
(
    input  logic                     com_en,
    input  logic [2:0]               act_mode,
    input  logic [SLOT_W-1:0]        slot,
    input  logic                     pol,
    output logic [MAX_COM*LVL_W-1:0] com_lvl
);

    logic [2:0] nslots;
    bias_e      bias;

    // Decode the active mode once for all commons.
    always_comb begin
        nslots = slots_of(act_mode);
        bias   = bias_of(act_mode);
    end

    for (genvar i = 0; i < MAX_COM; i++) begin : g_com
        logic active;
        logic sel;
        // Pick the level of common i.
        always_comb begin
            active = (3'(i) < nslots);
            sel    = (slot == SLOT_W'(i));
            if (!com_en || !active) begin
                com_lvl[i*LVL_W +: LVL_W] = LV_0;
            end else begin
                com_lvl[i*LVL_W +: LVL_W] = com_level(bias, sel, pol);
            end
        end
    end

endmodule

// File: rtl/lcd_seg_drive.sv
// Module: per-segment level encoder. A segment is selected only when the
// display is on and its bit in the addressed memory row is set.
module lcd_seg_drive
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 8
)(
    input  logic                     disp_on,
    input  logic [2:0]               act_mode,
    input  logic                     pol,
    input  logic [NUM_SEG-1:0]       seg_row,
    output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);

    bias_e bias;

    // Decode the bias once for all segments.
    always_comb begin
        bias = bias_of(act_mode);
    end

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
        // Pick the level of segment j.
        always_comb begin
            seg_lvl[j*LVL_W +: LVL_W] = seg_level(bias, disp_on && seg_row[j], pol);
        end
    end

endmodule

// File: rtl/lcd_drive_seq.sv
// Module: top of the LCD drive sequencer. Ties the mode register, the frame
// timer and the common/segment encoders together. Assumes the display memory
// returns seg_row combinationally for row_addr in the same cycle.
module lcd_drive_seq
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG  = 8,
    parameter int DIV_BASE = 6
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [15:0]              wr_mask,
    input  logic [15:0]              wr_data,
    output logic [15:0]              ctrl_rd,
    output logic                     ana_stop,
    output logic                     int_supply,
    output logic [1:0]               row_addr,
    input  logic [NUM_SEG-1:0]       seg_row,
    output logic [7:0]               com_lvl,
    output logic [2*NUM_SEG-1:0]     seg_lvl
);

    logic [15:0]       ctrl_q;
    logic [SLOT_W-1:0] slot;
    logic              pol;
    logic [2:0]        act_mode;
    logic [1:0]        act_div;
    logic              frame_end;

    lcd_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    lcd_frame_timer #(.DIV_BASE(DIV_BASE)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (ctrl_q[MODE_LSB +: 3]),
        .cfg_div   (ctrl_q[DIV_LSB +: 2]),
        .slot      (slot),
        .pol       (pol),
        .act_mode  (act_mode),
        .act_div   (act_div),
        .frame_end (frame_end)
    );

    lcd_com_drive u_com (
        .com_en   (ctrl_q[BIT_COMEN]),
        .act_mode (act_mode),
        .slot     (slot),
        .pol      (pol),
        .com_lvl  (com_lvl)
    );

    lcd_seg_drive #(.NUM_SEG(NUM_SEG)) u_seg (
        .disp_on  (ctrl_q[BIT_ON]),
        .act_mode (act_mode),
        .pol      (pol),
        .seg_row  (seg_row),
        .seg_lvl  (seg_lvl)
    );

    // Drive read-back, exported flags and memory row address.
    always_comb begin
        ctrl_rd    = ctrl_q;
        ana_stop   = ctrl_q[BIT_ASTOP];
        int_supply = ctrl_q[BIT_ISUP];
        row_addr   = slot;
    end

endmodule

// File: rtl/lcd_drive_seq_chk.sv
// Module: property checker for lcd_drive_seq, attached with bind below.
module lcd_drive_seq_chk #(
    parameter int NUM_SEG = 8
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [15:0]          ctrl_rd,
    input logic [1:0]           row_addr,
    input logic [7:0]           com_lvl,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic                 pol,
    input logic [2:0]           act_mode,
    input logic [1:0]           act_div,
    input logic                 frame_end
);

    logic [2*NUM_SEG-1:0] seg_ref;

    // Replicate segment 0 across all positions for the display-off check.
    always_comb begin
        for (int k = 0; k < NUM_SEG; k++) seg_ref[2*k +: 2] = seg_lvl[1:0];
    end

    // R1: unimplemented bits never read as 1
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd & ~16'hF073) == 16'h0000);

    // R2: no write strobe, register holds
    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_rd));

    // R4: row advances by one or wraps to zero
    a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr != $past(row_addr)) |->
            (row_addr == $past(row_addr) + 2'd1) || (row_addr == 2'd0));

    // R6: polarity flips at a frame end
    a_r6_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (pol != $past(pol)));

    // R6: polarity steady inside a frame
    a_r6_pol_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(pol));

    // R9: display off gives one common non-select code on all segments
    a_r9_off_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[15] |-> (seg_lvl == seg_ref));

    // R10: common enable low keeps commons at level 0
    a_r10_com_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[14] |-> (com_lvl == 8'h00));

    // R11: active configuration only changes at a frame end
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(act_mode) && $stable(act_div)));

endmodule

bind lcd_drive_seq lcd_drive_seq_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .ctrl_rd   (ctrl_rd),
    .row_addr  (row_addr),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl),
    .pol       (pol),
    .act_mode  (act_mode),
    .act_div   (act_div),
    .frame_end (frame_end)
);

// File: tb/lcd_drive_seq_bench.sv
// Directed bench for lcd_drive_seq with a reference sequencer built from the
// requirement text. Inputs change on negedge; outputs are sampled on negedge.
module lcd_drive_seq_bench;

    localparam int NSEG = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_mask = '0;
    logic [15:0]       wr_data = '0;
    logic [15:0]       ctrl_rd;
    logic              ana_stop, int_supply;
    logic [1:0]        row_addr;
    logic [NSEG-1:0]   seg_row;
    logic [7:0]        com_lvl;
    logic [2*NSEG-1:0] seg_lvl;
    logic [NSEG-1:0]   mem [4];

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    assign seg_row = mem[row_addr];

    lcd_drive_seq #(.NUM_SEG(NSEG), .DIV_BASE(6)) u_lcd_drive_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_data(wr_data), .ctrl_rd(ctrl_rd), .ana_stop(ana_stop),
        .int_supply(int_supply), .row_addr(row_addr), .seg_row(seg_row),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // ---------------- reference model ----------------
    logic [15:0] e_ctrl;
    int          m_pre, m_slot;
    logic        m_pol;
    logic [2:0]  m_mode;
    logic [1:0]  m_div;

    function automatic int nsl(input logic [2:0] md);
        if (md == 3'd0) return 4;
        if (md == 3'd1 || md == 3'd3) return 3;
        if (md == 3'd2) return 2;
        return 1;
    endfunction

    // 0 static, 1 half, 2 third
    function automatic int bias(input logic [2:0] md);
        if (md <= 3'd1) return 2;
        if (md <= 3'd3) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            e_ctrl <= '0; m_pre <= 0; m_slot <= 0; m_pol <= 1'b0;
            m_mode <= '0; m_div <= '0;
        end else begin
            if (wr_en) e_ctrl <= ((e_ctrl & ~wr_mask) | (wr_data & wr_mask)) & 16'hF073;
            if (m_pre == (64 << m_div) - 1) begin
                m_pre <= 0;
                if (m_slot == nsl(m_mode) - 1) begin
                    m_slot <= 0; m_pol <= ~m_pol;
                    m_mode <= e_ctrl[6:4]; m_div <= e_ctrl[1:0];
                end else m_slot <= m_slot + 1;
            end else m_pre <= m_pre + 1;
        end
    end

    function automatic logic [1:0] exp_com(input int i);
        int b = bias(m_mode);
        logic s = (i == m_slot);
        if (!e_ctrl[14] || i >= nsl(m_mode)) return 2'd0;
        if (b == 0) return m_pol ? 2'd3 : 2'd0;
        if (b == 1) return s ? (m_pol ? 2'd0 : 2'd3) : 2'd1;
        return s ? (m_pol ? 2'd0 : 2'd3) : (m_pol ? 2'd2 : 2'd1);
    endfunction

    function automatic logic [1:0] exp_seg(input int j);
        int b = bias(m_mode);
        logic s = e_ctrl[15] && mem[m_slot][j];
        if (b == 0) return s ? (m_pol ? 2'd0 : 2'd3) : (m_pol ? 2'd3 : 2'd0);
        if (b == 1) return s ? (m_pol ? 2'd3 : 2'd0) : (m_pol ? 2'd0 : 2'd3);
        return s ? (m_pol ? 2'd3 : 2'd0) : (m_pol ? 2'd1 : 2'd2);
    endfunction

    function automatic logic [7:0] exp_coms();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) v[2*i +: 2] = exp_com(i);
        return v;
    endfunction

    function automatic logic [2*NSEG-1:0] exp_segs();
        logic [2*NSEG-1:0] v;
        for (int j = 0; j < NSEG; j++) v[2*j +: 2] = exp_seg(j);
        return v;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [15:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_mask = '0;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (!(m_slot == 0 && m_pre == 0));
    endtask

    // Compare every output with the model for n cycles; one check per run.
    task automatic run_cmp(input int n, input string req);
        int bad = 0;
        longint fa = 0, fe = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (com_lvl !== exp_coms() || seg_lvl !== exp_segs() || row_addr !== 2'(m_slot)) begin
                if (bad == 0) begin
                    fa = {row_addr, com_lvl, seg_lvl};
                    fe = {2'(m_slot), exp_coms(), exp_segs()};
                end
                bad++;
            end
        end
        check(bad == 0, req, fa, fe);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(ctrl_rd == 16'h0000, "R1 reset value", ctrl_rd, 16'h0000);
        check(com_lvl == 8'h00, "R10 commons off at reset", com_lvl, 8'h00);
        check(seg_lvl == exp_segs(), "R9 segments non-select at reset", seg_lvl, exp_segs());
    endtask

    task automatic t_write_mask();
        wr(16'hFFFF, 16'hFFFF);
        check(ctrl_rd == 16'hF073, "R1 unused bits read zero", ctrl_rd, 16'hF073);
        wr(16'h0000, 16'h2000);
        check(ctrl_rd == 16'hD073, "R2 single-bit clear", ctrl_rd, 16'hD073);
        wr(16'hFFFF, 16'h0010);
        check(ctrl_rd == 16'hD073, "R2 single-bit set no change elsewhere", ctrl_rd, 16'hD073);
        wr(16'h0000, 16'hFFFF);
        check(ctrl_rd == 16'h0000, "R2 full write", ctrl_rd, 16'h0000);
    endtask

    task automatic t_mode(input logic [2:0] md, input logic [1:0] dv, input string req);
        wr({2'b11, 7'b0, md, 2'b00, dv}, 16'hFFFF);
        wait_frame();
        wait_frame();
        run_cmp(2 * nsl(md) * (64 << dv) + 5, req);
    endtask

    task automatic t_flags();
        int len = 0;
        wr(16'hF001, 16'hFFFF);
        check(ana_stop == 1'b1 && int_supply == 1'b1, "R3 flags exported", {ana_stop, int_supply}, 2'b11);
        wait_frame(); wait_frame();
        while (row_addr == 2'd0) begin @(negedge clk); len++; end
        check(len == 128, "R4 slot length divider 1 with flags set", len, 128);
        run_cmp(600, "R3 timing and levels unaffected by flags");
        wr(16'h0000, 16'h3000);
        check(ana_stop == 1'b0 && int_supply == 1'b0, "R3 flags cleared", {ana_stop, int_supply}, 2'b00);
    endtask

    task automatic t_polarity();
        logic [1:0] a, b;
        wr(16'hC040, 16'hFFFF);
        wait_frame(); wait_frame();
        a = com_lvl[1:0];
        repeat (64) @(negedge clk);
        b = com_lvl[1:0];
        check((a ^ b) == 2'b11 && (a == 2'd0 || a == 2'd3), "R6 static common inverts per frame", {a, b}, {a, ~a});
    endtask

    task automatic t_deferred();
        bit saw3 = 0, stuck = 1;
        wr(16'hC000, 16'hFFFF);
        wait_frame(); wait_frame();
        repeat (70) @(negedge clk);
        check(row_addr == 2'd1, "R4 slot 1 after one slot", row_addr, 1);
        wr(16'hC040, 16'h0070);
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (row_addr == 2'd3) saw3 = 1;
        end
        check(saw3, "R11 old mode finishes its frame", saw3, 1);
        wait_frame();
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (row_addr != 2'd0) stuck = 0;
        end
        check(stuck, "R11 new static mode holds slot 0", row_addr, 0);
    endtask

    task automatic t_off();
        wr(16'h4000, 16'hFFFF);
        wait_frame(); wait_frame();
        run_cmp(600, "R9 display off gives non-select");
        wr(16'h8000, 16'hFFFF);
        wait_frame(); wait_frame();
        run_cmp(600, "R10 common enable low holds commons at 0");
    endtask

    task automatic t_reserved();
        wr(16'hC070, 16'hFFFF);
        check(ctrl_rd == 16'hC070, "R5 reserved code reads back", ctrl_rd, 16'hC070);
        wait_frame(); wait_frame();
        run_cmp(300, "R5 reserved code drives static");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'hF0; mem[3] = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_mask();
        t_mode(3'b000, 2'd0, "R5 R7 R8 mux4 third bias");
        t_mode(3'b001, 2'd1, "R5 R7 R8 mux3 third bias");
        mem[0] = 8'h5A; mem[1] = 8'hFF; mem[2] = 8'h00;
        t_mode(3'b010, 2'd0, "R5 R7 R8 mux2 half bias");
        t_mode(3'b011, 2'd2, "R5 R7 R8 mux3 half bias");
        t_mode(3'b100, 2'd3, "R5 R7 R8 static");
        t_flags();
        t_polarity();
        t_deferred();
        t_off();
        t_reserved();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule